// File: doc/BRIEF.md
# Interrupt Timer Bank with Expiry Toggle

This block holds a bank of identical down-counting timers that an interrupt controller uses as periodic interrupt sources. Each timer has three registers on a small register bus: a reload register whose top bit stops the timer, a read-only live count register whose top bit flips every time the count runs out, and a vector/priority register whose top bit masks the interrupt. One more global register reports the timer clock frequency and resets to a value picked by a parameter.

A common tick enable advances every running timer by one step. When a timer runs out it reloads from its reload register, flips its toggle bit and, unless masked, sends a one-cycle request to the interrupt controller. Software clears the toggle bit with a specific sequence on the stop bit. Reads are combinational; writes take effect at the clock edge on which the write strobe is high.

Top module: `irq_timer_bank`

## Requirements
- R1: After reset every live count register reads 0, every reload register reads 0x80000000, every vector/priority register reads 0x80000000 and no interrupt request is high.
- R2: The frequency register reads 0 after reset when FREQ_SEL is 0 and 4160000 when it is 1; a bus write to it stores the full 32-bit value.
- R3: While bit 31 (stop) of a timer's reload register is set, ticks leave its live count unchanged.
- R4: A write that clears the stop bit while it was set loads bits 30:0 of the written value into the live count; each later cycle with tick_en high lowers it by one, and cycles with tick_en low leave it unchanged.
- R5: A tick that finds the live count at 1 or 0 reloads it from reload bits 30:0 and inverts bit 31 (toggle) of the live count register.
- R6: An expiring tick raises that timer's bit of tmr_irq for exactly the following cycle when bit 31 (mask) of its vector/priority register is clear, and not at all when it is set.
- R7: A reload register write clears the toggle bit only when the toggle is set, the stop bit was set and the written value has bit 31 clear; any other reload write keeps the toggle.
- R8: Bus writes to a live count register have no effect.
- R9: Writing a new reload value while the timer runs leaves the live count untouched; the new value is used at the next expiry.
- R10: A vector/priority write stores only bit 31, bits 19:16 and bits VEC_W-1:0; other bits read 0.
- R11: Address bit ADDR_W-1 selects the global region (select 0 = frequency register), bits TIDX_W+1:2 pick the timer, bits 1:0 pick 0 = live count, 1 = reload, 2 = vector/priority; access to one timer leaves the others unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | One-cycle count step for all running timers |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tmr_irq | output | NUM_TMR | Per-timer interrupt request pulse |

## Verification
The count path is driven with stopped ticks, plain ticks, ticks across an expiry and reload writes that land mid-period, which separates a timer that counts while stopped, reloads too early or adopts a new reload value at once from a correct one. The toggle bit is driven through all three clear cases (stop-then-release, release without stop, stop reasserted) so that a clear on a wrong sequence is caught. The interrupt is observed cycle by cycle around an expiry with the mask clear and set, which exposes a late, long or unmasked pulse, and an untouched timer is read at the end to expose address decode leaks.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int REG_W    = 32;
   localparam int STOP_BIT = 31;
   localparam int TOG_BIT  = 31;
   localparam int MASK_BIT = 31;
   localparam int PRI_LO   = 16;
   localparam int PRI_W    = 4;
   localparam int FREQ_ALT = 4160000;

   typedef enum logic [1:0] {
      SEL_COUNT  = 2'd0,
      SEL_RELOAD = 2'd1,
      SEL_VECPRI = 2'd2,
      SEL_SPARE  = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode
   import tmr_pkg::*;
#(
   parameter int NUM_TMR = 4,
   parameter int TIDX_W  = 2,
   parameter int ADDR_W  = 5
) (
   input  logic                  bus_we,
   input  logic [ADDR_W-1:0]     bus_addr,
   output logic [NUM_TMR-1:0]    reload_we,
   output logic [NUM_TMR-1:0]    vecpri_we,
   output logic                  freq_we,
   output logic                  acc_glob,
   output logic                  acc_valid,
   output logic [TIDX_W-1:0]     acc_idx,
   output reg_sel_e              acc_sel
);
   localparam logic [TIDX_W:0] NUM_L = (TIDX_W+1)'(NUM_TMR);

   assign acc_glob  = bus_addr[ADDR_W-1];
   assign acc_idx   = bus_addr[TIDX_W+1:2];
   assign acc_sel   = reg_sel_e'(bus_addr[1:0]);
   assign acc_valid = ({1'b0, acc_idx} < NUM_L);
   assign freq_we   = bus_we & acc_glob & (acc_sel == SEL_COUNT);

   for (genvar g = 0; g < NUM_TMR; g++) begin : g_strobe
      localparam logic [TIDX_W-1:0] IDX = TIDX_W'(g);
      logic hit;
      assign hit          = bus_we & ~acc_glob & (acc_idx == IDX);
      assign reload_we[g] = hit & (acc_sel == SEL_RELOAD);
      assign vecpri_we[g] = hit & (acc_sel == SEL_VECPRI);
   end
endmodule

// File: rtl/tmr_channel.sv
module tmr_channel
   import tmr_pkg::*;
#(
   parameter int VEC_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_en,
   input  logic             reload_we,
   input  logic             vecpri_we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] count_word,
   output logic [REG_W-1:0] reload_word,
   output logic [REG_W-1:0] vecpri_word,
   output logic             irq
);
   localparam logic [REG_W-1:0] VEC_KEEP = REG_W'((64'd1 << VEC_W) - 64'd1);
   localparam logic [REG_W-1:0] PRI_KEEP = REG_W'(((64'd1 << PRI_W) - 64'd1) << PRI_LO);
   localparam logic [REG_W-1:0] VP_KEEP  = (REG_W'(1) << MASK_BIT) | PRI_KEEP | VEC_KEEP;
   localparam logic [REG_W-1:0] VP_RST   = REG_W'(1) << MASK_BIT;
   localparam logic [REG_W-2:0] ONE      = (REG_W-1)'(1);

   logic             stop_q;
   logic [REG_W-2:0] reload_q;
   logic [REG_W-2:0] cnt_q;
   logic             tog_q;
   logic [REG_W-1:0] vp_q;
   logic             irq_q;

   logic release_now;
   logic running;
   logic expire;

   assign release_now = reload_we & stop_q & ~wdata[STOP_BIT];
   assign running     = ~stop_q;
   assign expire      = running & tick_en & (cnt_q <= ONE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stop_q   <= 1'b1;
         reload_q <= '0;
         cnt_q    <= '0;
         tog_q    <= 1'b0;
         irq_q    <= 1'b0;
      end else begin
         irq_q <= expire & ~vp_q[MASK_BIT];
         if (reload_we) begin
            stop_q   <= wdata[STOP_BIT];
            reload_q <= wdata[REG_W-2:0];
         end
         if (release_now) begin
            cnt_q <= wdata[REG_W-2:0];
            if (tog_q) tog_q <= 1'b0;
         end else if (running && tick_en) begin
            if (expire) begin
               cnt_q <= reload_q;
               tog_q <= ~tog_q;
            end else begin
               cnt_q <= cnt_q - ONE;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)         vp_q <= VP_RST;
      else if (vecpri_we) vp_q <= wdata & VP_KEEP;
   end

   assign count_word  = {tog_q, cnt_q};
   assign reload_word = {stop_q, reload_q};
   assign vecpri_word = vp_q;
   assign irq         = irq_q;
endmodule

// File: rtl/tmr_freq_reg.sv
module tmr_freq_reg
   import tmr_pkg::*;
#(
   parameter int FREQ_SEL = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] value
);
   logic [REG_W-1:0] rst_val;
   logic [REG_W-1:0] freq_q;

   if (FREQ_SEL == 0) begin : g_zero
      assign rst_val = '0;
   end else begin : g_alt
      assign rst_val = REG_W'(FREQ_ALT);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)  freq_q <= rst_val;
      else if (we) freq_q <= wdata;
   end

   assign value = freq_q;
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux
   import tmr_pkg::*;
#(
   parameter int NUM_TMR = 4,
   parameter int TIDX_W  = 2
) (
   input  logic                          acc_glob,
   input  logic                          acc_valid,
   input  logic [TIDX_W-1:0]             acc_idx,
   input  reg_sel_e                      acc_sel,
   input  logic [NUM_TMR-1:0][REG_W-1:0] count_words,
   input  logic [NUM_TMR-1:0][REG_W-1:0] reload_words,
   input  logic [NUM_TMR-1:0][REG_W-1:0] vecpri_words,
   input  logic [REG_W-1:0]              freq_word,
   output logic [REG_W-1:0]              rdata
);
   always_comb begin
      rdata = '0;
      if (acc_glob) begin
         if (acc_sel == SEL_COUNT) rdata = freq_word;
      end else if (acc_valid) begin
         unique case (acc_sel)
            SEL_COUNT:  rdata = count_words[acc_idx];
            SEL_RELOAD: rdata = reload_words[acc_idx];
            SEL_VECPRI: rdata = vecpri_words[acc_idx];
            default:    rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/irq_timer_bank.sv
module irq_timer_bank
   import tmr_pkg::*;
#(
   parameter  int NUM_TMR  = 4,
   parameter  int VEC_W    = 16,
   parameter  int FREQ_SEL = 0,
   localparam int TIDX_W   = (NUM_TMR > 1) ? $clog2(NUM_TMR) : 1,
   localparam int ADDR_W   = TIDX_W + 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick_en,
   input  logic               bus_we,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic [31:0]        bus_wdata,
   output logic [31:0]        bus_rdata,
   output logic [NUM_TMR-1:0] tmr_irq
);
   if (NUM_TMR < 1 || NUM_TMR > 16) begin : g_bad_num
      $error("NUM_TMR must lie in 1..16");
   end
   if (VEC_W < 1 || VEC_W > 16) begin : g_bad_vec
      $error("VEC_W must lie in 1..16");
   end
   if (FREQ_SEL != 0 && FREQ_SEL != 1) begin : g_bad_freq
      $error("FREQ_SEL must be 0 or 1");
   end

   logic [NUM_TMR-1:0]            reload_we;
   logic [NUM_TMR-1:0]            vecpri_we;
   logic                          freq_we;
   logic                          acc_glob;
   logic                          acc_valid;
   logic [TIDX_W-1:0]             acc_idx;
   reg_sel_e                      acc_sel;
   logic [NUM_TMR-1:0][REG_W-1:0] cnt_words;
   logic [NUM_TMR-1:0][REG_W-1:0] reload_words;
   logic [NUM_TMR-1:0][REG_W-1:0] vp_words;
   logic [REG_W-1:0]              freq_word;

   tmr_decode #(
      .NUM_TMR (NUM_TMR),
      .TIDX_W  (TIDX_W),
      .ADDR_W  (ADDR_W)
   ) dec_i (
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .reload_we (reload_we),
      .vecpri_we (vecpri_we),
      .freq_we   (freq_we),
      .acc_glob  (acc_glob),
      .acc_valid (acc_valid),
      .acc_idx   (acc_idx),
      .acc_sel   (acc_sel)
   );

   for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
      tmr_channel #(
         .VEC_W (VEC_W)
      ) chan_i (
         .clk         (clk),
         .rst_n       (rst_n),
         .tick_en     (tick_en),
         .reload_we   (reload_we[t]),
         .vecpri_we   (vecpri_we[t]),
         .wdata       (bus_wdata),
         .count_word  (cnt_words[t]),
         .reload_word (reload_words[t]),
         .vecpri_word (vp_words[t]),
         .irq         (tmr_irq[t])
      );
   end

   tmr_freq_reg #(
      .FREQ_SEL (FREQ_SEL)
   ) freq_i (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (freq_we),
      .wdata (bus_wdata),
      .value (freq_word)
   );

   tmr_rdmux #(
      .NUM_TMR (NUM_TMR),
      .TIDX_W  (TIDX_W)
   ) rd_i (
      .acc_glob     (acc_glob),
      .acc_valid    (acc_valid),
      .acc_idx      (acc_idx),
      .acc_sel      (acc_sel),
      .count_words  (cnt_words),
      .reload_words (reload_words),
      .vecpri_words (vp_words),
      .freq_word    (freq_word),
      .rdata        (bus_rdata)
   );
endmodule

// File: rtl/irq_timer_bank_chk.sv
module irq_timer_bank_chk #(
   parameter int NUM_TMR = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     tick_en,
   input logic                     bus_we,
   input logic [NUM_TMR-1:0]       tmr_irq,
   input logic [NUM_TMR-1:0][31:0] cnt_words,
   input logic [NUM_TMR-1:0][31:0] reload_words,
   input logic [NUM_TMR-1:0][31:0] vp_words
);
   for (genvar i = 0; i < NUM_TMR; i++) begin : g_chk
      p_irq_after_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
         tmr_irq[i] |-> $past(tick_en));

      p_irq_unmasked_r6: assert property (@(posedge clk) disable iff (!rst_n)
         tmr_irq[i] |-> !$past(vp_words[i][31]));

      p_stop_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (reload_words[i][31] && $past(reload_words[i][31])) |-> $stable(cnt_words[i][30:0]));

      p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (!$past(tick_en) && !$past(bus_we)) |-> $stable(cnt_words[i]));

      p_toggle_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(cnt_words[i][31]) |-> $past(tick_en));

      p_toggle_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
         $fell(cnt_words[i][31]) |-> ($past(tick_en) || $past(bus_we)));
   end
endmodule

bind irq_timer_bank irq_timer_bank_chk #(.NUM_TMR(NUM_TMR)) chk_i (
   .clk          (clk),
   .rst_n        (rst_n),
   .tick_en      (tick_en),
   .bus_we       (bus_we),
   .tmr_irq      (tmr_irq),
   .cnt_words    (cnt_words),
   .reload_words (reload_words),
   .vp_words     (vp_words)
);

// File: tb/irq_timer_bank_tb_top.sv
module irq_timer_bank_tb_top;
   localparam int NT = 4;
   localparam int AW = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick_en = 1'b0;
   logic          bus_we = 1'b0;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NT-1:0] tmr_irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   irq_timer_bank dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_en   (tick_en),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .tmr_irq   (tmr_irq)
   );

   typedef struct packed {
      logic          we;
      logic [AW-1:0] addr;
      logic [31:0]   wd;
      logic [7:0]    n;
      logic [AW-1:0] ra;
      logic [31:0]   exp;
      logic [7:0]    req;
   } vec_t;

   // timer 0: live count at 0, reload at 1
   localparam vec_t VECS [16] = '{
      '{1'b1, 5'd1, 32'h8000_0005, 8'd3, 5'd0, 32'h0000_0000, 8'd3},  // R3 stopped
      '{1'b1, 5'd1, 32'h0000_0005, 8'd0, 5'd0, 32'h0000_0005, 8'd4},  // R4 release loads
      '{1'b0, 5'd0, 32'h0,         8'd2, 5'd0, 32'h0000_0003, 8'd4},  // R4 decrement
      '{1'b0, 5'd0, 32'h0,         8'd3, 5'd0, 32'h8000_0005, 8'd5},  // R5 expiry
      '{1'b1, 5'd0, 32'h0000_1234, 8'd0, 5'd0, 32'h8000_0005, 8'd8},  // R8 read-only
      '{1'b1, 5'd1, 32'h0000_0002, 8'd0, 5'd0, 32'h8000_0005, 8'd9},  // R9 no immediate load
      '{1'b0, 5'd0, 32'h0,         8'd4, 5'd0, 32'h8000_0001, 8'd9},  // R9 old period runs
      '{1'b0, 5'd0, 32'h0,         8'd1, 5'd0, 32'h0000_0002, 8'd9},  // R9 new reload used
      '{1'b1, 5'd1, 32'h8000_0002, 8'd3, 5'd0, 32'h0000_0002, 8'd3},  // R3 stop again
      '{1'b1, 5'd1, 32'h0000_0002, 8'd2, 5'd0, 32'h8000_0002, 8'd5},  // R5 toggle set
      '{1'b1, 5'd1, 32'h8000_0002, 8'd0, 5'd0, 32'h8000_0002, 8'd7},  // R7 stop keeps toggle
      '{1'b1, 5'd1, 32'h0000_0003, 8'd0, 5'd0, 32'h0000_0003, 8'd7},  // R7 release clears
      '{1'b0, 5'd0, 32'h0,         8'd3, 5'd0, 32'h8000_0003, 8'd5},  // R5 toggle set again
      '{1'b1, 5'd1, 32'h0000_0004, 8'd0, 5'd0, 32'h8000_0003, 8'd7},  // R7 running write keeps
      '{1'b0, 5'd0, 32'h0,         8'd2, 5'd0, 32'h8000_0001, 8'd4},  // R4 counting
      '{1'b0, 5'd0, 32'h0,         8'd1, 5'd0, 32'h0000_0004, 8'd9}   // R9 new reload, toggle back
   };

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic ticks(input int n);
      if (n > 0) begin
         @(negedge clk);
         tick_en = 1'b1;
         repeat (n) @(negedge clk);
         tick_en = 1'b0;
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      logic [NT-1:0] seen;

      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state of all timers
      for (int t = 0; t < NT; t++) begin
         rd(AW'(t*4 + 0), v); chk($sformatf("R1 count%0d", t), v, 32'h0);
         rd(AW'(t*4 + 1), v); chk($sformatf("R1 reload%0d", t), v, 32'h8000_0000);
         rd(AW'(t*4 + 2), v); chk($sformatf("R1 vecpri%0d", t), v, 32'h8000_0000);
      end
      chk("R1 irq", {28'h0, tmr_irq}, 32'h0);

      // R2 frequency register
      rd(5'd16, v); chk("R2 freq reset", v, 32'h0);
      wr(5'd16, 32'h0BAD_F00D);
      rd(5'd16, v); chk("R2 freq write", v, 32'h0BAD_F00D);

      // main vector table on timer 0
      for (int k = 0; k < 16; k++) begin
         if (VECS[k].we) wr(VECS[k].addr, VECS[k].wd);
         ticks(int'(VECS[k].n));
         rd(VECS[k].ra, v);
         chk($sformatf("R%0d vec%0d", VECS[k].req, k), v, VECS[k].exp);
      end
      chk("R6 masked timer0 irq", {28'h0, tmr_irq}, 32'h0);

      // R10 vecpri field keep
      wr(5'd10, 32'hFFFF_FFFF);
      rd(5'd10, v); chk("R10 vecpri keep", v, 32'h800F_FFFF);

      // R6 unmasked pulse timing on timer 2
      wr(5'd10, 32'h0005_0042);
      wr(5'd9, 32'h0000_0003);
      @(negedge clk); tick_en = 1'b1;
      @(negedge clk); chk("R6 no irq tick1", {28'h0, tmr_irq}, 32'h0);
      @(negedge clk); chk("R6 no irq tick2", {28'h0, tmr_irq}, 32'h0);
      @(negedge clk); tick_en = 1'b0;
      chk("R6 irq on expiry", {28'h0, tmr_irq}, 32'h4);
      @(negedge clk); chk("R6 irq one cycle", {28'h0, tmr_irq}, 32'h0);
      rd(5'd8, v); chk("R5 timer2 reload toggle", v, 32'h8000_0003);

      // R6 masked expiry
      wr(5'd10, 32'h8005_0042);
      seen = '0;
      @(negedge clk); tick_en = 1'b1;
      repeat (3) begin
         @(negedge clk); seen |= tmr_irq;
      end
      tick_en = 1'b0;
      @(negedge clk); seen |= tmr_irq;
      chk("R6 masked no irq", {28'h0, seen}, 32'h0);
      rd(5'd8, v); chk("R5 timer2 toggle back", v, 32'h0000_0003);

      // R11 untouched timers and spare select
      rd(5'd12, v); chk("R11 count3", v, 32'h0);
      rd(5'd13, v); chk("R11 reload3", v, 32'h8000_0000);
      rd(5'd6,  v); chk("R11 vecpri1", v, 32'h8000_0000);
      rd(5'd3,  v); chk("R11 spare select", v, 32'h0);
      rd(5'd16, v); chk("R11 freq kept", v, 32'h0BAD_F00D);

      finish_run();
   end
endmodule